// File: doc/BRIEF.md
# Serial Delay-Setting Loader

This block receives the settings for a group of programmable delay lines over a three-wire serial link: a serial clock, a serial data input and a commit strobe. All three are asynchronous to the system clock. They are brought into the system clock domain through synchronizers. The rising edges of the serial clock and of the strobe are then found by edge detectors. Each rising serial-clock edge moves one bit into a frame-long shift register. A rising strobe edge copies the frame into a holding register, which drives the active settings.

A frame has four lines of four address bits each plus one enable bit per line, 20 bits in all. The enables come first, for the highest-numbered line down to line 1. The addresses follow for line 1 up to the last line, each sent most significant bit first. The bit leaving the far end of the shift register drives a serial output. Several loaders can therefore be chained output-to-input while they share the serial clock and the strobe. A one-cycle update pulse tells the downstream delay-line logic that new settings have just taken effect.

Top module: `dcfg_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, line_en_o and line_addr_o are all zero, update_o is 0 and sdat_o is 0.
- R2: Each rising edge on sclk_i moves exactly one bit into the shift register. A steady level or a falling edge on sclk_i moves nothing, and sdat_o then holds its value.
- R3: After a commit, line_en_o[n] equals the enable bit sent at frame position LINES-n (positions count from 1 in send order). This means the first bit sent sets the enable of the last line and the fourth bit sent sets the enable of line 1. An enable of 1 switches the line on and 0 switches it off.
- R4: After a commit, the address of line n+1 (line_addr_o[n*4 +: 4]) is taken from frame positions 5+4n to 8+4n, with the first of those four bits as the address MSB.
- R5: Shifting never changes line_en_o or line_addr_o. These outputs change only in the cycle in which update_o is 1.
- R6: Each rising edge on latch_i gives exactly one cycle of update_o = 1. Holding latch_i high gives no further pulse.
- R7: sdat_o shows the oldest bit held in the shift register. While a new frame is shifted in, sdat_o gives the previous frame in its original send order. After 20 rising edges it shows the first bit of the new frame.
- R8: update_o and the new settings appear after the third rising system-clock edge that follows a change of latch_i from 0 to 1. A serial-clock edge likewise takes effect at the third system-clock edge. This latency is the two synchronizer stages plus the edge register.
- R9: If the strobe edge and a serial-clock edge are detected in the same cycle, the commit captures the frame as it stood before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdat_i | input | 1 | Serial data, asynchronous |
| latch_i | input | 1 | Commit strobe, asynchronous |
| sdat_o | output | 1 | Oldest shift-register bit, for chaining |
| line_en_o | output | LINES | Active enable per line, line 1 in bit 0 |
| line_addr_o | output | LINES*ADDR_W | Active address per line, line 1 in the low slice |
| update_o | output | 1 | One-cycle pulse when new settings take effect |

## Verification
The bench builds the block with its default parameters: four lines, four address bits and two synchronizer stages. These give the 20-bit frame and a three-cycle edge latency. With these values the full enable-first, address-MSB-first bit layout can be checked against hand-written frames. Shifting out an old frame while a new one enters can be followed bit by bit. The exact cycle at which a strobe edge takes effect can be pinned down. A strobe held high for many cycles is included, and so is a reset in the middle of a frame.

// File: rtl/dcfg_pkg.sv
// Package: shared helpers for the serial delay-setting loader.
// Gives the frame length and the bit positions of each field inside the
// shift register. Index 0 of the register is the most recently received bit.
package dcfg_pkg;

    // Total frame bits: one enable plus the address bits per line.
    function automatic int frame_bits(input int lines, input int addr_w);
        return lines * (addr_w + 1);
    endfunction

    // Register index of the enable of line n (0-based) once a full frame is held.
    function automatic int en_index(input int lines, input int addr_w, input int n);
        return lines * addr_w + n;
    endfunction

    // Register index of the address MSB of line n (0-based).
    function automatic int addr_msb_index(input int lines, input int addr_w, input int n);
        return lines * addr_w - 1 - n * addr_w;
    endfunction

endpackage

// File: rtl/dcfg_sync.sv
// Module: dcfg_sync
// A multi-bit synchronizer chain with STAGES flops per bit.
// Assumes every bit is an independent, slowly changing level. No bus
// coherence is implied. The bits reset to 0.
module dcfg_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    // Later stages resolve metastability one flop at a time.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dcfg_edge.sv
// Module: dcfg_edge
// Rising-edge detector on a level that is already synchronous.
// The output is high for one cycle when the level goes from 0 to 1.
// Assumes the level was 0 during reset.
module dcfg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/dcfg_shifter.sv
// Module: dcfg_shifter
// A frame-long shift register. New bits enter at index 0, and the oldest bit
// sits at the top index and drives the serial output for chaining.
// Assumes shift_i is a single-cycle strobe.
module dcfg_shifter #(
    parameter int FRAME = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [FRAME-1:0] frame_o,
    output logic             sout_o
);

    logic [FRAME-1:0] sr_q;

    // Move the register by one place on each detected serial-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[FRAME-2:0], bit_i};
    end

    assign frame_o = sr_q;
    assign sout_o  = sr_q[FRAME-1];

endmodule

// File: rtl/dcfg_hold.sv
// Module: dcfg_hold
// Decodes the shift-register contents into per-line enables and addresses.
// These are copied into holding registers on a load strobe, and a one-cycle
// update pulse is raised alongside the new values.
// Assumes load_i is a single-cycle strobe.
module dcfg_hold
    import dcfg_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [LINES*(ADDR_W+1)-1:0] frame_i,
    output logic [LINES-1:0]          en_o,
    output logic [LINES*ADDR_W-1:0]   addr_o,
    output logic                      update_o
);

    logic [LINES-1:0]        nxt_en;
    logic [LINES*ADDR_W-1:0] nxt_addr;
    logic [LINES-1:0]        en_q;
    logic [LINES*ADDR_W-1:0] addr_q;
    logic                    upd_q;

    // Per-line field extraction from the fixed frame layout.
    for (genvar n = 0; n < LINES; n++) begin : g_line
        localparam int EN_POS  = en_index(LINES, ADDR_W, n);
        localparam int MSB_POS = addr_msb_index(LINES, ADDR_W, n);
        assign nxt_en[n]                  = frame_i[EN_POS];
        assign nxt_addr[n*ADDR_W +: ADDR_W] = frame_i[MSB_POS -: ADDR_W];
    end

    // Commit decoded settings on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            addr_q <= '0;
        end else if (load_i) begin
            en_q   <= nxt_en;
            addr_q <= nxt_addr;
        end
    end

    // Flag the cycle in which the new settings first show.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= load_i;
    end

    assign en_o     = en_q;
    assign addr_o   = addr_q;
    assign update_o = upd_q;

endmodule

// File: rtl/dcfg_top.sv
// Module: dcfg_top
// The serial delay-setting loader. It synchronizes the serial clock, data and
// strobe, detects the rising edges of the serial clock and strobe, shifts the
// data into a frame register and commits the decoded frame on the strobe.
// Assumes the serial inputs stay steady for several system clocks
// around each serial-clock edge.
module dcfg_top #(
    parameter int LINES       = 4,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_i,
    input  logic                    sdat_i,
    input  logic                    latch_i,
    output logic                    sdat_o,
    output logic [LINES-1:0]        line_en_o,
    output logic [LINES*ADDR_W-1:0] line_addr_o,
    output logic                    update_o
);

    localparam int FRAME = dcfg_pkg::frame_bits(LINES, ADDR_W);

    logic [2:0]       sync_vec;
    logic             sclk_rise;
    logic             latch_rise;
    logic [FRAME-1:0] frame;

    dcfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({latch_i, sdat_i, sclk_i}),
        .sync_o  (sync_vec)
    );

    dcfg_edge u_sclk_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_vec[0]),
        .rise_o  (sclk_rise)
    );

    dcfg_edge u_latch_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_vec[2]),
        .rise_o  (latch_rise)
    );

    dcfg_shifter #(.FRAME(FRAME)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sclk_rise),
        .bit_i   (sync_vec[1]),
        .frame_o (frame),
        .sout_o  (sdat_o)
    );

    dcfg_hold #(.LINES(LINES), .ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (latch_rise),
        .frame_i  (frame),
        .en_o     (line_en_o),
        .addr_o   (line_addr_o),
        .update_o (update_o)
    );

endmodule

// File: rtl/dcfg_checker.sv
// Module: dcfg_checker
// Temporal properties of the loader. It is bound to dcfg_top and watches
// the detected edges and the outputs.
module dcfg_checker #(
    parameter int LINES  = 4,
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sclk_rise,
    input logic                    latch_rise,
    input logic                    sdat_o,
    input logic [LINES-1:0]        line_en_o,
    input logic [LINES*ADDR_W-1:0] line_addr_o,
    input logic                    update_o
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (line_en_o == '0 && line_addr_o == '0 && !update_o && !sdat_o));

    p_no_edge_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(sdat_o));

    p_quiet_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> ($stable(line_en_o) && $stable(line_addr_o)));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    p_commit_follows_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> update_o);

endmodule

bind dcfg_top dcfg_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_rise   (sclk_rise),
    .latch_rise  (latch_rise),
    .sdat_o      (sdat_o),
    .line_en_o   (line_en_o),
    .line_addr_o (line_addr_o),
    .update_o    (update_o)
);

// File: tb/dcfg_top_bench.sv
// Bench for dcfg_top. A behavioural model built on queues follows the
// inputs and is compared with the outputs on every clock. Directed checks
// cover the reset state, the field layout and the latency.
module dcfg_top_bench;

    localparam int LINES = 4;
    localparam int AW    = 4;
    localparam int SYNC  = 2;
    localparam int FRAME = LINES * (AW + 1);
    localparam int ABITS = LINES * AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic latch = 1'b0;
    logic             sdat_o;
    logic [LINES-1:0] line_en_o;
    logic [ABITS-1:0] line_addr_o;
    logic             update_o;

    int checks = 0;
    int fails = 0;
    bit started = 1'b0;

    dcfg_top #(.LINES(LINES), .ADDR_W(AW), .SYNC_STAGES(SYNC)) u_dcfg_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .sdat_i      (sdat),
        .latch_i     (latch),
        .sdat_o      (sdat_o),
        .line_en_o   (line_en_o),
        .line_addr_o (line_addr_o),
        .update_o    (update_o)
    );

    always #5 clk = ~clk;

    // Reference model state.
    bit mq[$];
    bit hc[$];
    bit hd[$];
    bit hl[$];
    logic [LINES-1:0] m_en;
    logic [ABITS-1:0] m_addr;
    bit m_upd;
    bit c_rise, l_rise, d_bit;

    task automatic model_reset();
        mq.delete(); hc.delete(); hd.delete(); hl.delete();
        for (int i = 0; i < FRAME; i++) mq.push_back(1'b0);
        for (int i = 0; i <= SYNC; i++) begin
            hc.push_back(1'b0); hd.push_back(1'b0); hl.push_back(1'b0);
        end
        m_en = '0; m_addr = '0; m_upd = 1'b0;
    endtask

    // Model step on each rising clock edge; mq[0] is the oldest bit.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            c_rise = hc[SYNC-1] && !hc[SYNC];
            l_rise = hl[SYNC-1] && !hl[SYNC];
            d_bit  = hd[SYNC-1];
            m_upd  = l_rise;
            if (l_rise) begin
                for (int n = 0; n < LINES; n++) begin
                    m_en[n] = mq[LINES-1-n];
                    for (int j = 0; j < AW; j++)
                        m_addr[n*AW + (AW-1-j)] = mq[LINES + n*AW + j];
                end
            end
            if (c_rise) begin
                void'(mq.pop_front());
                mq.push_back(d_bit);
            end
            hc.push_front(sclk);  void'(hc.pop_back());
            hd.push_front(sdat);  void'(hd.pop_back());
            hl.push_front(latch); void'(hl.pop_back());
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R7", "sdat_o vs model", {31'b0, sdat_o}, {31'b0, mq[0]});
            chk("R5", "line_en_o vs model", {28'b0, line_en_o}, {28'b0, m_en});
            chk("R4", "line_addr_o vs model", {16'b0, line_addr_o}, {16'b0, m_addr});
            chk("R6", "update_o vs model", {31'b0, update_o}, {31'b0, m_upd});
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk); sdat = b; sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Vector MSB is the first bit sent (frame position 1).
    task automatic send_frame(input logic [FRAME-1:0] f);
        for (int i = FRAME-1; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic strobe(input int hold);
        @(negedge clk); latch = 1'b1;
        repeat (hold) @(negedge clk);
        latch = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    localparam logic [FRAME-1:0] FRAME_A = {4'b1101, 4'h5, 4'hA, 4'h3, 4'hF};
    localparam logic [FRAME-1:0] FRAME_B = {4'b0010, 4'h0, 4'hF, 4'h8, 4'h1};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held in reset
        chk("R1", "en in reset", {28'b0, line_en_o}, 32'h0);
        chk("R1", "addr in reset", {16'b0, line_addr_o}, 32'h0);
        chk("R1", "update in reset", {31'b0, update_o}, 32'h0);
        chk("R1", "sdat_o in reset", {31'b0, sdat_o}, 32'h0);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);

        // R3 / R4: load a known frame and commit
        send_frame(FRAME_A);
        chk("R5", "en before commit", {28'b0, line_en_o}, 32'h0);
        // R8: exact latency of the commit
        @(negedge clk); latch = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "no update after two edges", {31'b0, update_o}, 32'h0);
        chk("R8", "old enables after two edges", {28'b0, line_en_o}, 32'h0);
        @(negedge clk);
        chk("R8", "update after three edges", {31'b0, update_o}, 32'h1);
        chk("R3", "enables layout", {28'b0, line_en_o}, 32'hD);
        chk("R4", "address layout", {16'b0, line_addr_o}, 32'hF3A5);
        @(negedge clk);
        chk("R6", "pulse lasts one cycle", {31'b0, update_o}, 32'h0);
        repeat (20) @(negedge clk);
        chk("R6", "held strobe gives no second pulse", {31'b0, update_o}, 32'h0);
        latch = 1'b0;
        repeat (5) @(negedge clk);

        // R2: data toggling with the serial clock steady moves nothing
        for (int i = 0; i < 6; i++) begin
            sdat = ~sdat;
            repeat (3) @(negedge clk);
        end
        chk("R2", "sdat_o unchanged without clock edge", {31'b0, sdat_o}, {31'b0, FRAME_A[FRAME-1]});

        // R7: shift a second frame; old frame leaves first, new bit 1 ends on top
        send_frame(FRAME_B);
        chk("R7", "new bit 1 after full frame", {31'b0, sdat_o}, {31'b0, FRAME_B[FRAME-1]});
        chk("R5", "enables kept while shifting", {28'b0, line_en_o}, 32'hD);
        chk("R5", "addresses kept while shifting", {16'b0, line_addr_o}, 32'hF3A5);
        strobe(4);
        chk("R3", "second frame enables", {28'b0, line_en_o}, 32'h2);
        chk("R4", "second frame addresses", {16'b0, line_addr_o}, 32'h18F0);

        // R9: strobe and serial clock rising together commit the pre-shift frame
        @(negedge clk); sdat = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b1; latch = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0; latch = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "coincident commit enables", {28'b0, line_en_o}, 32'h2);
        chk("R9", "coincident commit addresses", {16'b0, line_addr_o}, 32'h18F0);

        // R1: reset in the middle of a frame
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "en after mid-frame reset", {28'b0, line_en_o}, 32'h0);
        chk("R1", "addr after mid-frame reset", {16'b0, line_addr_o}, 32'h0);
        chk("R1", "sdat_o after mid-frame reset", {31'b0, sdat_o}, 32'h0);
        send_frame(FRAME_A);
        strobe(2);
        chk("R3", "reload after reset", {28'b0, line_en_o}, 32'hD);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule